// File: doc/BRIEF.md
# Windowed Watchdog Supervisor with Failure Escalation

This block supervises a host processor through a periodic trigger. Each trigger strobe carries a setting: a mode bit that selects plain time-out or window supervision, and a period code. The period is 256 base ticks plus 48 ticks for each code step, so codes 0 to 16 give 256 to 1024 ticks. A missed period is a failure. In window mode a trigger that comes too soon is also a failure. Each failure pulls the processor reset output low for a fixed number of ticks and puts the supervision back to its default setting.

Consecutive failures are counted. A valid trigger clears the count. Depending on a configuration input, the limp-home output latches after the first failure or after the second one in a row. A trigger whose period code is out of range is still accepted as a service, but the current setting is kept and a one-cycle interrupt is raised. The current setting, the failure count and the cause of the last failure are visible on status outputs.

Top module: `wdg_supervisor`

## Requirements
- R1: While rst_ni is low and after it is released: wdg_rst_no=1, limp_o=0, irq_o=0, fail_cnt_o=0, cause_o=00, cur_win_o=0, cur_code_o=0, and elapsed ticks=0.
- R2: Period P = 256 + 48*code ticks. Codes 0..16 are valid. The default setting is code 0 in time-out mode (cur_win_o=0).
- R3: If elapsed reaches P-1 and a tick arrives with no trigger in that cycle, a late failure occurs. wdg_rst_no is 0 from the next cycle.
- R4: With cur_win_o=1, a trigger while elapsed < floor(P*9/20) is an early failure. With cur_win_o=0, every trigger that is not ignored is valid.
- R5: A valid trigger sets elapsed to 0, fail_cnt_o to 0 and cause_o to 00. If its code is 16 or less, trig_win_i and trig_code_i become the setting from the next cycle.
- R6: A valid trigger with a code above 16 leaves the setting unchanged and gives irq_o=1 for exactly the next cycle.
- R7: After a failure, wdg_rst_no stays 0 for RST_TICKS ticks. During that time triggers are ignored and elapsed stays 0.
- R8: Each failure increments fail_cnt_o, saturating at 3. limp_o sets when the count reaches 1 (two_fail_i=0) or 2 (two_fail_i=1). Once set, it stays set until rst_ni.
- R9: A failure returns the setting to code 0 in time-out mode.
- R10: A trigger in the same cycle as the tick that would end the period is valid, and no failure occurs.
- R11: With en_i=0, no failure is detected, elapsed is held at 0 and the setting is held at its default.
- R12: cause_o reports the last failure: 01 for early, 10 for late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick strobe |
| en_i | input | 1 | Supervision enable |
| trig_i | input | 1 | Trigger strobe |
| trig_win_i | input | 1 | Requested mode: 1 window, 0 time-out |
| trig_code_i | input | 5 | Requested period code |
| two_fail_i | input | 1 | 1: limp-home after two consecutive failures |
| wdg_rst_no | output | 1 | Processor reset, active low |
| limp_o | output | 1 | Limp-home, sticky |
| irq_o | output | 1 | Invalid-setting interrupt pulse |
| fail_cnt_o | output | 2 | Consecutive failure count |
| cause_o | output | 2 | Last failure cause |
| cur_win_o | output | 1 | Active mode |
| cur_code_o | output | 5 | Active period code |

## Verification
A trigger and the tick that completes the period can land in the same clock cycle. The trigger has to win (R10). The bench provokes this by counting exactly P-1 ticks after a valid trigger and then strobing the trigger in the cycle of the last tick. A control run one cycle later must instead give a late failure. A second overlap is a trigger arriving while the reset pulse is still active. Both cases are judged cycle by cycle against a behavioural model of elapsed time, setting, reset count and failure count.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_EARLY = 2'b01,
    CAUSE_LATE  = 2'b10
  } cause_e;

  typedef struct packed {
    logic ok;
    logic early;
    logic late;
  } wdg_evt_t;
endpackage

// File: rtl/wdg_setting.sv
module wdg_setting #(
  parameter int CODE_W   = 5,
  parameter int MAX_CODE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ok_i,
  input  logic              fail_i,
  input  logic              req_win_i,
  input  logic [CODE_W-1:0] req_code_i,
  output logic              win_o,
  output logic [CODE_W-1:0] code_o,
  output logic              irq_o
);
  logic code_ok;
  assign code_ok = (req_code_i <= CODE_W'(MAX_CODE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_o  <= 1'b0;
      code_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= ok_i & ~code_ok;
      if (fail_i || !en_i) begin
        win_o  <= 1'b0;
        code_o <= '0;
      end else if (ok_i && code_ok) begin
        win_o  <= req_win_i;
        code_o <= req_code_i;
      end
    end
  end

  AST_BAD_CODE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_i && !code_ok) |=> ($stable(code_o) && $stable(win_o))); // R6
  AST_FAIL_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |=> (code_o == '0 && !win_o)); // R9
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int CODE_W     = 5,
  parameter int BASE_TICKS = 256,
  parameter int STEP_TICKS = 48,
  parameter int MAX_CODE   = 16,
  parameter int OPEN_NUM   = 9,
  parameter int OPEN_DEN   = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              tick_i,
  input  logic              trig_i,
  input  logic              win_i,
  input  logic [CODE_W-1:0] code_i,
  output wdg_evt_t          evt_o
);
  localparam int MAX_P = BASE_TICKS + STEP_TICKS * MAX_CODE;
  localparam int PW    = $clog2(MAX_P * (OPEN_NUM + 1) + 1);

  logic [PW-1:0] cnt_q, period_w, open_w;
  logic          last_w;

  assign period_w = PW'(BASE_TICKS) + PW'(STEP_TICKS) * PW'(code_i);

  generate
    if (OPEN_NUM == 0) begin : g_no_window
      assign open_w = '0;
    end else begin : g_window
      assign open_w = (period_w * PW'(OPEN_NUM)) / PW'(OPEN_DEN);
    end
  endgenerate

  assign last_w = (cnt_q == period_w - PW'(1));

  always_comb begin
    evt_o.early = act_i & trig_i & win_i & (cnt_q < open_w);
    evt_o.ok    = act_i & trig_i & ~evt_o.early;
    evt_o.late  = act_i & tick_i & ~trig_i & last_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      cnt_q <= '0;
    else if (!act_i || evt_o.ok || evt_o.early || evt_o.late) cnt_q <= '0;
    else if (tick_i)                                  cnt_q <= cnt_q + PW'(1);
  end

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < period_w); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> cnt_q == '0); // R7
  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({evt_o.ok, evt_o.early, evt_o.late})); // R10
endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate
  import wdg_pkg::*;
#(
  parameter int RST_TICKS = 16,
  parameter int FC_W      = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  wdg_evt_t        evt_i,
  input  logic            two_fail_i,
  output logic            wdg_rst_no,
  output logic            limp_o,
  output logic [FC_W-1:0] fail_cnt_o,
  output cause_e          cause_o
);
  localparam int RC_W = $clog2(RST_TICKS + 1);
  localparam logic [FC_W-1:0] FC_MAX = '1;

  logic [RC_W-1:0] rc_q;
  logic [FC_W-1:0] fc_nxt, limit_w;
  logic            fail_w;

  assign fail_w     = evt_i.early | evt_i.late;
  assign fc_nxt     = (fail_cnt_o == FC_MAX) ? FC_MAX : fail_cnt_o + FC_W'(1);
  assign limit_w    = two_fail_i ? FC_W'(2) : FC_W'(1);
  assign wdg_rst_no = (rc_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rc_q       <= '0;
      fail_cnt_o <= '0;
      limp_o     <= 1'b0;
      cause_o    <= CAUSE_NONE;
    end else begin
      if (fail_w)                      rc_q <= RC_W'(RST_TICKS);
      else if (tick_i && rc_q != '0)   rc_q <= rc_q - RC_W'(1);
      if (fail_w) begin
        fail_cnt_o <= fc_nxt;
        cause_o    <= evt_i.early ? CAUSE_EARLY : CAUSE_LATE;
        if (fc_nxt >= limit_w) limp_o <= 1'b1;
      end else if (evt_i.ok) begin
        fail_cnt_o <= '0;
        cause_o    <= CAUSE_NONE;
      end
    end
  end

  AST_FAIL_PULLS_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_w |=> !wdg_rst_no); // R3
  AST_RELEASE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdg_rst_no) |-> $past(tick_i)); // R7
  AST_LIMP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limp_o |=> limp_o); // R8
  AST_OK_CLEARS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.ok |=> (fail_cnt_o == '0 && cause_o == CAUSE_NONE)); // R5
  AST_CAUSE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.early |=> cause_o == CAUSE_EARLY); // R12
endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
  import wdg_pkg::*;
#(
  parameter int CODE_W     = 5,
  parameter int BASE_TICKS = 256,
  parameter int STEP_TICKS = 48,
  parameter int MAX_CODE   = 16,
  parameter int OPEN_NUM   = 9,
  parameter int OPEN_DEN   = 20,
  parameter int RST_TICKS  = 16,
  parameter int FC_W       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              trig_i,
  input  logic              trig_win_i,
  input  logic [CODE_W-1:0] trig_code_i,
  input  logic              two_fail_i,
  output logic              wdg_rst_no,
  output logic              limp_o,
  output logic              irq_o,
  output logic [FC_W-1:0]   fail_cnt_o,
  output logic [1:0]        cause_o,
  output logic              cur_win_o,
  output logic [CODE_W-1:0] cur_code_o
);
  wdg_evt_t evt;
  cause_e   cause;
  logic     act;

  assign act     = en_i & wdg_rst_no;
  assign cause_o = cause;

  wdg_setting #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) setting_i (
    .clk_i, .rst_ni, .en_i,
    .ok_i(evt.ok), .fail_i(evt.early | evt.late),
    .req_win_i(trig_win_i), .req_code_i(trig_code_i),
    .win_o(cur_win_o), .code_o(cur_code_o), .irq_o
  );

  wdg_timer #(
    .CODE_W(CODE_W), .BASE_TICKS(BASE_TICKS), .STEP_TICKS(STEP_TICKS),
    .MAX_CODE(MAX_CODE), .OPEN_NUM(OPEN_NUM), .OPEN_DEN(OPEN_DEN)
  ) timer_i (
    .clk_i, .rst_ni, .act_i(act), .tick_i, .trig_i,
    .win_i(cur_win_o), .code_i(cur_code_o), .evt_o(evt)
  );

  wdg_escalate #(.RST_TICKS(RST_TICKS), .FC_W(FC_W)) esc_i (
    .clk_i, .rst_ni, .tick_i, .evt_i(evt), .two_fail_i,
    .wdg_rst_no, .limp_o, .fail_cnt_o, .cause_o(cause)
  );

  AST_DISABLED_NO_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(fail_cnt_o)); // R11
endmodule

// File: tb/wdg_supervisor_tb_top.sv
module wdg_supervisor_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, en_i = 1'b0, trig_i = 1'b0, trig_win_i = 1'b0, two_fail_i = 1'b1;
  logic [4:0] trig_code_i = '0;
  logic wdg_rst_no, limp_o, irq_o, cur_win_o;
  logic [1:0] fail_cnt_o, cause_o;
  logic [4:0] cur_code_o;

  int vectors = 0, miscompares = 0, tick_every = 1, tick_ph = 0;
  string phase = "R1 reset";

  always #2 clk_i = ~clk_i;

  wdg_supervisor dut_i (.*);

  // behavioural reference
  int m_cnt, m_code, m_rc, m_fc, m_cause;
  bit m_win, m_limp, m_irq;
  localparam int RST_T = 16;

  always @(posedge clk_i or negedge rst_ni) begin : mdl
    int p, op;
    bit act, early, ok, late, fail;
    if (!rst_ni) begin
      m_cnt = 0; m_code = 0; m_win = 0; m_rc = 0; m_fc = 0; m_cause = 0;
      m_limp = 0; m_irq = 0;
    end else begin
      p = 256 + 48 * m_code;
      op = (p * 9) / 20;
      act = en_i && (m_rc == 0);
      early = act && trig_i && m_win && (m_cnt < op);
      ok = act && trig_i && !early;
      late = act && tick_i && !trig_i && (m_cnt == p - 1);
      fail = early || late;
      m_irq = ok && (trig_code_i > 16);
      if (fail) begin
        m_rc = RST_T;
        m_fc = (m_fc < 3) ? m_fc + 1 : 3;
        if (m_fc >= (two_fail_i ? 2 : 1)) m_limp = 1;
        m_cause = early ? 1 : 2;
        m_code = 0; m_win = 0; m_cnt = 0;
      end else begin
        if (tick_i && m_rc > 0) m_rc--;
        if (ok) begin
          m_cnt = 0; m_fc = 0; m_cause = 0;
          if (trig_code_i <= 16) begin m_code = trig_code_i; m_win = trig_win_i; end
        end else if (!act) m_cnt = 0;
        else if (tick_i) m_cnt++;
        if (!en_i) begin m_code = 0; m_win = 0; end
      end
    end
  end

  task automatic chk(string nm, int got, int exp);
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s got %0d exp %0d at %0t", phase, nm, got, exp, $time);
    end
  endtask

  task automatic step();
    tick_i = (tick_ph % tick_every) == 0;
    tick_ph++;
    @(negedge clk_i);
    vectors++;
    chk("wdg_rst_no R3/R7", int'(wdg_rst_no), int'(m_rc == 0));
    chk("limp_o R8", int'(limp_o), int'(m_limp));
    chk("irq_o R6", int'(irq_o), int'(m_irq));
    chk("fail_cnt_o R8", int'(fail_cnt_o), m_fc);
    chk("cause_o R12", int'(cause_o), m_cause);
    chk("cur_win_o R5/R9", int'(cur_win_o), int'(m_win));
    chk("cur_code_o R2/R9", int'(cur_code_o), m_code);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic trigger(bit w, int c);
    trig_i = 1'b1; trig_win_i = w; trig_code_i = 5'(c);
    step();
    trig_i = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    miscompares++;
    $display("FAIL R3 watchdog expired got running exp finished");
    summary();
  end

  initial begin
    @(negedge clk_i);
    idle(3);
    rst_ni = 1'b1;
    phase = "R1 reset state";
    step();
    chk("R1 rst", int'(wdg_rst_no), 1);
    chk("R1 limp", int'(limp_o), 0);

    phase = "R11 disabled";
    for (int i = 0; i < 4; i++) begin idle(9); trigger(1, 3); end
    idle(300);
    chk("R11 no fail", int'(fail_cnt_o), 0);

    en_i = 1'b1;
    phase = "R2 R3 default timeout";
    idle(258);
    chk("R3 reset low", int'(wdg_rst_no), 0);
    phase = "R7 triggers ignored in reset";
    trigger(0, 4); idle(3); trigger(1, 2);
    idle(20);
    chk("R7 code unchanged", int'(cur_code_o), 0);

    phase = "R5 valid trigger";
    trigger(0, 2);
    chk("R5 count cleared", int'(fail_cnt_o), 0);
    idle(100);
    trigger(1, 2);
    phase = "R4 early in window";
    idle(50);
    trigger(1, 2);
    chk("R12 early cause", int'(cause_o), 1);
    idle(30);
    phase = "R4 timeout mode any trigger valid";
    trigger(0, 0);
    idle(2);
    trigger(0, 0);
    phase = "R6 invalid code";
    trigger(1, 20);
    chk("R6 irq", int'(irq_o), 1);
    step();
    chk("R6 irq one cycle", int'(irq_o), 0);

    phase = "R10 trigger on last tick";
    trigger(0, 1);
    idle(303);
    trigger(0, 1);
    chk("R10 no fail", int'(wdg_rst_no), 1);
    phase = "R3 control one cycle late";
    idle(304);
    chk("R3 late fail", int'(wdg_rst_no), 0);
    chk("R12 late cause", int'(cause_o), 2);
    phase = "R8 second failure limp";
    idle(300);
    chk("R8 limp two", int'(limp_o), 1);
    phase = "R8 saturate";
    idle(300);
    chk("R8 sat", int'(fail_cnt_o), 3);

    phase = "R9 R4 window late sparse tick";
    rst_ni = 1'b0; step(); rst_ni = 1'b1;
    two_fail_i = 1'b0;
    tick_every = 3;
    idle(20);
    trigger(1, 0);
    idle(500);
    trigger(1, 0);
    idle(200 * 3);
    phase = "R8 single failure limp";
    idle(300 * 3);
    chk("R8 limp one", int'(limp_o), 1);
    phase = "R9 default after failure";
    idle(80);
    chk("R9 default", int'(cur_win_o), 0);
    summary();
  end
endmodule